// File: doc/BRIEF.md
# NRZI Tape Write Channel Controller

This block drives the digital side of a multi-track magnetic tape write path. The host presents a character on the data lines and marks it with a write strobe. Each track whose data bit is one then runs its own deskew delay, and the track's head-drive flip-flop toggles when that delay ends. This is NRZI recording: a one produces a flux reversal and a zero leaves the head current unchanged. The per-track delays correct static skew between head gaps, and software sets them through a small configuration write port.

After the last strobe of a block, the controller waits a fixed gap and then issues an end-of-block reset. It counts four character times on a 7-track deck and eight on a 9-track deck. The reset returns every head driver that is still set to the cleared state, which records the longitudinal check character. A tape mark goes through the same path as any other strobed character.

Interlock inputs for motion, write enable, select and ready hold every track cleared while any of them is low. A separate registered output enables write power when the deck permits writing.

Top module: `tape_write_ctrl`

## Requirements
- R1: A strobe rising edge starts the deskew delay only on tracks whose `data_i` bit is 1. A track whose bit is 0 keeps its head state.
- R2: Track t loads a 4-bit delay D through `cfg_we_i`/`cfg_track_i`/`cfg_delay_i` (reset value 2). The head bit changes on the (D+1)-th clock edge after the edge on which the strobe is first seen high.
- R3: Each completed delay inverts that track's head bit. Two ones in a row on a track return its head bit to its previous level.
- R4: A gap of GAP = CHAR_CYC x (8 for 9 tracks, 4 for 7 tracks) clocks after the last strobe rising edge, `eob_reset_o` is high for exactly one cycle. From that cycle on, all head bits are 0.
- R5: A strobe rising edge that arrives before the gap has expired restarts the gap count from that edge.
- R6: While any of `motion_i`, `wr_enable_i`, `select_i`, `ready_i` is 0, `head_o` is 0 in the same cycle. Pending deskew delays and the gap count are cancelled, so no toggle and no end-of-block reset follow.
- R7: `wr_power_o` is 1 exactly one cycle after `wr_enable_i`, `select_i`, `ready_i` and `file_permit_i` are all 1.
- R8: After synchronous reset, `head_o`, `eob_reset_o` and `wr_power_o` are 0.
- R9: A strobe held high for several cycles counts as one character.
- R10: A strobe rising edge seen while the interlock is active starts neither a toggle nor a gap count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Write one track's deskew delay |
| cfg_track_i | input | TRK_W | Track index for the delay write |
| cfg_delay_i | input | DLY_W | Deskew delay value in clocks |
| strobe_i | input | 1 | Write strobe, acted on at its rising edge |
| data_i | input | N_TRACKS | Character bits, one per track |
| motion_i | input | 1 | Tape in motion |
| wr_enable_i | input | 1 | Write enabled |
| select_i | input | 1 | Deck selected |
| ready_i | input | 1 | Deck ready |
| file_permit_i | input | 1 | File-protect permission to write |
| head_o | output | N_TRACKS | Head-drive state per track |
| eob_reset_o | output | 1 | One-cycle end-of-block reset pulse |
| wr_power_o | output | 1 | Write power enable |

## Verification
The hardest state to reach from the ports is an interlock drop that lands while deskew delays are still pending and the gap timer is running. A correct design must then drop every head bit, suppress the toggles that were still due and never emit the reset. The bench reaches this state by programming long delays on the upper tracks, strobing a full character, and pulling `motion_i` low two cycles later. It then waits well past the gap. A second case is a gap restarted by a mid-block strobe: the bench checks that the pulse appears at GAP after the second edge and not after the first.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef struct packed {
        logic motion;
        logic wr_en;
        logic select;
        logic ready;
    } interlock_t;

    function automatic int gap_chars(input int n_tracks);
        return (n_tracks == 9) ? 8 : 4;
    endfunction

    function automatic logic interlock_ok(input interlock_t s);
        return s.motion & s.wr_en & s.select & s.ready;
    endfunction

endpackage

// File: rtl/tw_deskew_lane.sv
module tw_deskew_lane #(
    parameter int DLY_W    = 4,
    parameter int DLY_INIT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [DLY_W-1:0] cfg_dly,
    input  logic             start,
    input  logic             clear,
    input  logic             eob_clr,
    output logic             head
);
    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] cnt_q;
    logic             busy_q;
    logic             head_q;
    logic             done;

    assign done = busy_q && (cnt_q == '0);
    assign head = head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= DLY_W'(DLY_INIT);
        end else if (cfg_we) begin
            dly_q <= cfg_dly;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= dly_q;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear)  head_q <= 1'b0;
        else if (eob_clr)  head_q <= 1'b0;
        else if (done)     head_q <= ~head_q;
    end

    // R6: an interlock cycle leaves the lane idle and cleared
    a_r6_clear_cancels: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!head_q && !busy_q));

    // R3: the head bit moves only on a finished delay, a clear or an end of block
    a_r3_toggle_source: assert property (@(posedge clk) disable iff (rst)
        (head_q != $past(head_q)) |-> $past(done || clear || eob_clr));

    // R2: a start loads the configured delay
    a_r2_delay_loaded: assert property (@(posedge clk) disable iff (rst)
        (start && !clear) |=> (busy_q && cnt_q == $past(dly_q)));

endmodule

// File: rtl/tw_gap_timer.sv
module tw_gap_timer #(
    parameter int GAP_CYC = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic clear,
    output logic fire,
    output logic eob
);
    localparam int CNT_W = $clog2(GAP_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             eob_q;

    assign fire = armed_q && (cnt_q == '0) && !start && !clear;
    assign eob  = eob_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            armed_q <= 1'b1;
            cnt_q   <= CNT_W'(GAP_CYC - 1);
        end else if (armed_q) begin
            if (cnt_q == '0) armed_q <= 1'b0;
            else             cnt_q   <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) eob_q <= 1'b0;
        else     eob_q <= fire;
    end

    // R4: the end-of-block pulse lasts a single cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        eob_q |=> !eob_q);

    // R5: a new strobe re-arms the gap and suppresses the pulse
    a_r5_restart: assert property (@(posedge clk) disable iff (rst)
        (start && !clear) |=> (armed_q && !eob_q));

endmodule

// File: rtl/tape_write_ctrl.sv
module tape_write_ctrl
    import tw_pkg::*;
#(
    parameter int N_TRACKS = 9,
    parameter int CHAR_CYC = 16,
    parameter int DLY_W    = 4,
    parameter int DLY_INIT = 2,
    localparam int TRK_W   = $clog2(N_TRACKS),
    localparam int GAP_CYC = gap_chars(N_TRACKS) * CHAR_CYC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we_i,
    input  logic [TRK_W-1:0]    cfg_track_i,
    input  logic [DLY_W-1:0]    cfg_delay_i,
    input  logic                strobe_i,
    input  logic [N_TRACKS-1:0] data_i,
    input  logic                motion_i,
    input  logic                wr_enable_i,
    input  logic                select_i,
    input  logic                ready_i,
    input  logic                file_permit_i,
    output logic [N_TRACKS-1:0] head_o,
    output logic                eob_reset_o,
    output logic                wr_power_o
);
    interlock_t          ctl;
    logic                hold_clr;
    logic                strobe_q;
    logic                rise;
    logic                gap_fire;
    logic [N_TRACKS-1:0] head_q;
    logic                power_q;

    assign ctl      = '{motion: motion_i, wr_en: wr_enable_i,
                        select: select_i, ready: ready_i};
    assign hold_clr = ~interlock_ok(ctl);
    assign rise     = strobe_i & ~strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe_i;
    end

    tw_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk   (clk),
        .rst   (rst),
        .start (rise & ~hold_clr),
        .clear (hold_clr),
        .fire  (gap_fire),
        .eob   (eob_reset_o)
    );

    for (genvar t = 0; t < N_TRACKS; t++) begin : g_lane
        tw_deskew_lane #(.DLY_W(DLY_W), .DLY_INIT(DLY_INIT)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .cfg_we  (cfg_we_i && (cfg_track_i == TRK_W'(t))),
            .cfg_dly (cfg_delay_i),
            .start   (rise & data_i[t] & ~hold_clr),
            .clear   (hold_clr),
            .eob_clr (gap_fire),
            .head    (head_q[t])
        );
    end

    assign head_o = head_q & {N_TRACKS{~hold_clr}};

    always_ff @(posedge clk) begin
        if (rst) power_q <= 1'b0;
        else     power_q <= wr_enable_i & select_i & ready_i & file_permit_i;
    end
    assign wr_power_o = power_q;

    // R4: every head register is cleared when the end-of-block pulse shows
    a_r4_heads_cleared: assert property (@(posedge clk) disable iff (rst)
        eob_reset_o |-> (head_q == '0));

    // R7: power follows the file permission of the previous cycle
    a_r7_power_permit: assert property (@(posedge clk) disable iff (rst)
        wr_power_o |-> $past(file_permit_i && wr_enable_i));

    // R10: a strobe under interlock leaves the gap quiet on the next cycle
    a_r10_strobe_blocked: assert property (@(posedge clk) disable iff (rst)
        (rise && hold_clr) |=> !eob_reset_o);

endmodule

// File: tb/tb_tape_write_ctrl.sv
module tb_tape_write_ctrl;
    localparam int NT  = 9;
    localparam int CC  = 16;
    localparam int GAP = 8 * CC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_trk = '0;
    logic [3:0]    cfg_dly = '0;
    logic          strobe = 1'b0;
    logic [NT-1:0] data = '0;
    logic          motion = 1'b0, wen = 1'b0, sel = 1'b0, rdy = 1'b0, fp = 1'b0;
    logic [NT-1:0] head_o;
    logic          eob_o, pwr_o;

    always #2 clk = ~clk;

    tape_write_ctrl dut (
        .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_track_i(cfg_trk),
        .cfg_delay_i(cfg_dly), .strobe_i(strobe), .data_i(data),
        .motion_i(motion), .wr_enable_i(wen), .select_i(sel), .ready_i(rdy),
        .file_permit_i(fp), .head_o(head_o), .eob_reset_o(eob_o),
        .wr_power_o(pwr_o)
    );

    int    checks = 0, errors = 0, eob_n = 0;
    string cur_req = "R8";
    bit    done_flag = 0;

    // behavioural reference model
    int            m_dly [NT];
    int            m_cnt [NT];
    bit            m_busy[NT];
    logic [NT-1:0] m_head;
    int            m_gap;
    bit            m_armed, m_eob, m_pwr, m_prev;
    bit            m_rise, m_il, m_fire, m_done;

    always @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NT; t++) begin
                m_dly[t] = 2; m_cnt[t] = 0; m_busy[t] = 0;
            end
            m_head = '0; m_gap = 0; m_armed = 0; m_eob = 0; m_pwr = 0; m_prev = 0;
        end else begin
            m_il   = !(motion && wen && sel && rdy);
            m_rise = strobe && !m_prev;
            m_fire = m_armed && m_gap == 0 && !m_rise && !m_il;
            m_eob  = m_fire;
            if (m_il) m_armed = 0;
            else if (m_rise) begin m_armed = 1; m_gap = GAP - 1; end
            else if (m_armed) begin
                if (m_gap == 0) m_armed = 0; else m_gap--;
            end
            for (int t = 0; t < NT; t++) begin
                m_done = m_busy[t] && m_cnt[t] == 0;
                if (m_il || m_fire) m_head[t] = 1'b0;
                else if (m_done)    m_head[t] = ~m_head[t];
                if (m_il) m_busy[t] = 0;
                else if (m_rise && data[t]) begin m_busy[t] = 1; m_cnt[t] = m_dly[t]; end
                else if (m_busy[t]) begin
                    if (m_cnt[t] == 0) m_busy[t] = 0; else m_cnt[t]--;
                end
            end
            if (cfg_we) m_dly[cfg_trk] = int'(cfg_dly);
            m_pwr  = wen && sel && rdy && fp;
            m_prev = strobe;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst && !done_flag) begin
            logic [NT-1:0] exp_h;
            exp_h = (motion && wen && sel && rdy) ? m_head : '0;
            checks++;
            if (head_o !== exp_h || eob_o !== m_eob || pwr_o !== m_pwr) begin
                errors++;
                $display("FAIL %s cycle: head %b eob %b pwr %b, expected head %b eob %b pwr %b",
                         cur_req, head_o, eob_o, pwr_o, exp_h, m_eob, m_pwr);
            end
            if (eob_o === 1'b1) eob_n++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic do_strobe(input logic [NT-1:0] d, input int hold);
        @(negedge clk);
        data = d; strobe = 1'b1;
        repeat (hold) @(negedge clk);
        strobe = 1'b0; data = '0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        tick(3);
        @(negedge clk); rst = 1'b0;
        tick(1);
        // R8 reset state
        chk(head_o == '0, "R8 head", int'(head_o), 0);
        chk(eob_o == 1'b0 && pwr_o == 1'b0, "R8 eob/pwr", int'({eob_o, pwr_o}), 0);

        // R7 write power
        cur_req = "R7";
        @(negedge clk); motion = 1; wen = 1; sel = 1; rdy = 1; fp = 1;
        tick(1);
        chk(pwr_o == 1'b1, "R7 power on", int'(pwr_o), 1);
        @(negedge clk); fp = 0;
        tick(1);
        chk(pwr_o == 1'b0, "R7 power off without permit", int'(pwr_o), 0);
        @(negedge clk); fp = 1;

        // R2 configure delay t+1 on each track
        cur_req = "R2";
        for (int t = 0; t < NT; t++) begin
            @(negedge clk); cfg_we = 1; cfg_trk = 4'(t); cfg_dly = 4'(t + 1);
        end
        @(negedge clk); cfg_we = 0;
        tick(2);

        // R2 exact timing on track 8 (delay 9)
        @(negedge clk); data = 9'h100; strobe = 1'b1;
        tick(10);
        chk(head_o[8] == 1'b0, "R2 before delay end", int'(head_o[8]), 0);
        tick(1);
        chk(head_o[8] == 1'b1, "R2 at delay end", int'(head_o[8]), 1);
        @(negedge clk); strobe = 0; data = '0;
        tick(GAP + 4);
        chk(eob_n == 1, "R4 pulse count", eob_n, 1);
        chk(head_o == '0, "R4 heads cleared", int'(head_o), 0);

        // R1, R9 held strobe, mixed pattern
        cur_req = "R9";
        do_strobe(9'b101010101, 3);
        tick(15);
        chk(head_o == 9'b101010101, "R9 single toggle per held strobe", int'(head_o), 9'h155);
        chk(head_o[1] == 1'b0, "R1 zero bit keeps head", int'(head_o[1]), 0);

        // R3 second one on same tracks toggles back
        cur_req = "R3";
        do_strobe(9'b100000001, 1);
        tick(15);
        chk(head_o == 9'b001010100, "R3 toggle back", int'(head_o), 9'h054);

        // R5 restart of gap: the last strobe was the R3 strobe
        cur_req = "R5";
        base = eob_n;
        do_strobe(9'b000000010, 1);
        tick(GAP - 20);
        chk(eob_n == base, "R5 no pulse from earlier strobe", eob_n, base);
        tick(30);
        chk(eob_n == base + 1, "R5 pulse after last strobe", eob_n, base + 1);
        chk(head_o == '0, "R4 check character cleared heads", int'(head_o), 0);

        // R6 interlock during an active block
        cur_req = "R6";
        base = eob_n;
        do_strobe(9'h1FF, 1);
        tick(2);
        @(negedge clk); motion = 0;
        tick(1);
        chk(head_o == '0, "R6 heads cleared", int'(head_o), 0);
        @(negedge clk); motion = 1;
        tick(GAP + 10);
        chk(head_o == '0, "R6 pending toggles dropped", int'(head_o), 0);
        chk(eob_n == base, "R6 no end-of-block pulse", eob_n, base);

        // R10 strobe while interlocked
        cur_req = "R10";
        @(negedge clk); rdy = 0;
        do_strobe(9'h0FF, 2);
        @(negedge clk); rdy = 1;
        tick(GAP + 10);
        chk(head_o == '0, "R10 no toggle", int'(head_o), 0);
        chk(eob_n == base, "R10 no pulse", eob_n, base);

        // R1 all-zero character: no toggles but gap runs
        cur_req = "R1";
        do_strobe('0, 1);
        tick(20);
        chk(head_o == '0, "R1 zero character", int'(head_o), 0);
        tick(GAP);
        chk(eob_n == base + 1, "R4 pulse after zero character", eob_n, base + 1);

        finish_run();
    end
endmodule